// File: doc/BRIEF.md
# Sequential Prefetch Stream Buffer

This block sits next to a cache and keeps a short queue of blocks fetched ahead of demand. When the cache misses on a block and the buffer cannot supply it, the buffer is cleared and restarted at the block after the missed one. It then issues memory reads for the following blocks on its own until every slot holds, or is waiting for, a block. The cache fetches the missed block itself, and the block after it ends up in the buffer.

Every cache lookup is presented to the buffer in the same cycle as the cache tag check. Only the oldest entry, the head, is compared. When the head matches on a cache miss, the block goes to the cache over the refill port and leaves the queue. Its slot is reused at once for the block just past the current tail, so the queue refills itself. If the head block has been requested but not yet returned, the match still counts as a buffer hit. In that case the refill is delivered when the data lands.

The memory port carries a tag with each read. When the buffer restarts, the stream identifier in that tag changes. Any data still in flight for the abandoned stream is then recognised and dropped.

Top module: `stream_prefetch_buf`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `lk_hit`, `refill_valid` and `mreq_valid` are all 0.
- R2: A lookup with `lk_miss` low has no effect. There is no `lk_hit` and no refill, and the head entry is still there for a later lookup.
- R3: A cache miss that does not match the head clears the buffer. The buffer then issues exactly DEPTH reads, for the missed block address plus 1 through plus DEPTH, in ascending order.
- R4: A cache miss that matches a head whose data is present raises `lk_hit` in the next cycle. In that same cycle `refill_valid` is high, with the head's block address on `refill_addr` and its data on `refill_data`.
- R5: A cache miss that matches a head whose data is still outstanding raises `lk_hit` in the next cycle with no refill. The refill follows once the data returns. Lookups made while the refill is waiting are ignored.
- R6: After each refill, exactly one new read is issued, for the block DEPTH positions past the delivered one.
- R7: Only the head is compared. A miss that names a block held in a later entry is treated as a buffer miss, which clears and restarts the buffer.
- R8: A read response whose stream identifier differs from the current stream is discarded and never reaches the refill port.
- R9: The read tag is {stream identifier, slot index}, with the slot index in the low bits. The identifier is 1 for the first stream after reset. The slots of a fresh stream are requested in order 0, 1, 2, and so on. A read held while `mreq_ready` is low is not lost: it is issued once `mreq_ready` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | A cache lookup is presented this cycle |
| lk_miss | input | 1 | The cache missed on this lookup |
| lk_addr | input | ADDR_W | Block address of the lookup |
| lk_hit | output | 1 | The previous cycle's lookup matched the buffer head |
| refill_valid | output | 1 | A block is being handed to the cache |
| refill_addr | output | ADDR_W | Block address of the refill |
| refill_data | output | DATA_W | Block contents of the refill |
| mreq_valid | output | 1 | A prefetch read is offered to memory |
| mreq_ready | input | 1 | Memory accepts the offered read |
| mreq_addr | output | ADDR_W | Block address of the read |
| mreq_tag | output | SID_W+IDX_W | Stream identifier and slot index of the read |
| mrsp_valid | input | 1 | Read data is returned this cycle |
| mrsp_tag | input | SID_W+IDX_W | Tag echoed from the read |
| mrsp_data | input | DATA_W | Returned block contents |

## Verification
Two things can land in the same cycle. One is a head hit that hands out a block and reuses its slot. The other is either a returning prefetch for another slot or the acceptance of a new read. The bench provokes this by issuing lookups back to back with a three-cycle memory latency, so rotations overlap with arriving data. It judges the result by the refill address and data, and by the later hits that follow. A restart can also coincide with stale data still in flight. For this, memory responses are held back across a restart and then released. The refill must carry the new stream's data, not the old stream's.

// File: rtl/sb_pkg.sv
package sb_pkg;
  // Life cycle of one buffer slot.
  typedef enum logic [1:0] {
    SL_IDLE  = 2'd0,  // no stream allocated
    SL_NEED  = 2'd1,  // address assigned, read not yet accepted
    SL_PEND  = 2'd2,  // read accepted, data outstanding
    SL_READY = 2'd3   // data stored
  } slot_st_t;
endpackage

// File: rtl/sb_pick.sv
// Lowest-index request wins.
module sb_pick #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/sb_data_ram.sv
// Simple dual-port storage with a registered read, suited to RAM inference.
module sb_data_ram #(
  parameter int DEPTH = 4,
  parameter int IW    = 2,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [IW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/stream_prefetch_buf.sv
// DEPTH must be a power of two.
module stream_prefetch_buf
  import sb_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4,
  parameter int SID_W  = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          lk_valid,
  input  logic                          lk_miss,
  input  logic [ADDR_W-1:0]             lk_addr,
  output logic                          lk_hit,
  output logic                          refill_valid,
  output logic [ADDR_W-1:0]             refill_addr,
  output logic [DATA_W-1:0]             refill_data,
  output logic                          mreq_valid,
  input  logic                          mreq_ready,
  output logic [ADDR_W-1:0]             mreq_addr,
  output logic [SID_W+((DEPTH>1)?$clog2(DEPTH):1)-1:0] mreq_tag,
  input  logic                          mrsp_valid,
  input  logic [SID_W+((DEPTH>1)?$clog2(DEPTH):1)-1:0] mrsp_tag,
  input  logic [DATA_W-1:0]             mrsp_data
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int TAG_W = SID_W + IDX_W;

  // Slot state
  slot_st_t          st   [DEPTH];
  logic [ADDR_W-1:0] sa   [DEPTH];
  logic [IDX_W-1:0]  hp;
  logic [ADDR_W-1:0] tail_addr;
  logic [SID_W-1:0]  sid;
  logic              wait_q;

  // Read issue: the lowest slot still needing a read
  logic [DEPTH-1:0] need_vec;
  logic             req_found;
  logic [IDX_W-1:0] req_idx;

  for (genvar g = 0; g < DEPTH; g++) begin : g_need
    assign need_vec[g] = (st[g] == SL_NEED);
  end

  sb_pick #(.N(DEPTH), .IW(IDX_W)) pick_i (
    .req   (need_vec),
    .found (req_found),
    .idx   (req_idx)
  );

  assign mreq_valid = req_found;
  assign mreq_addr  = sa[req_idx];
  assign mreq_tag   = {sid, req_idx};

  logic req_fire;
  assign req_fire = mreq_valid & mreq_ready;

  // Response decode: stale streams are dropped
  logic [SID_W-1:0] rsp_sid;
  logic [IDX_W-1:0] rsp_idx;
  logic             rsp_ok;
  assign rsp_sid = mrsp_tag[TAG_W-1:IDX_W];
  assign rsp_idx = mrsp_tag[IDX_W-1:0];
  assign rsp_ok  = mrsp_valid && (rsp_sid == sid) && (st[rsp_idx] == SL_PEND);

  // Lookup against the head only
  logic look, head_match, do_flush, deliver, go_wait;
  assign look       = lk_valid && lk_miss && !wait_q;
  assign head_match = look && (st[hp] != SL_IDLE) && (sa[hp] == lk_addr);
  assign do_flush   = look && !head_match;
  assign deliver    = (head_match || wait_q) && (st[hp] == SL_READY);
  assign go_wait    = head_match && (st[hp] != SL_READY);

  sb_data_ram #(.DEPTH(DEPTH), .IW(IDX_W), .DW(DATA_W)) ram_i (
    .clk   (clk),
    .we    (rsp_ok && !do_flush),
    .waddr (rsp_idx),
    .wdata (mrsp_data),
    .raddr (hp),
    .rdata (refill_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) begin
        st[i] <= SL_IDLE;
        sa[i] <= '0;
      end
      hp           <= '0;
      tail_addr    <= '0;
      sid          <= '0;
      wait_q       <= 1'b0;
      lk_hit       <= 1'b0;
      refill_valid <= 1'b0;
      refill_addr  <= '0;
    end else begin
      lk_hit       <= head_match;
      refill_valid <= deliver;
      if (deliver) refill_addr <= sa[hp];
      if (do_flush) begin
        // restart: slot k holds miss address + 1 + k, head at slot 0
        for (int i = 0; i < DEPTH; i++) begin
          st[i] <= SL_NEED;
          sa[i] <= lk_addr + ADDR_W'(i + 1);
        end
        hp        <= '0;
        tail_addr <= lk_addr + ADDR_W'(DEPTH + 1);
        sid       <= sid + 1'b1;
        wait_q    <= 1'b0;
      end else begin
        if (req_fire) st[req_idx] <= SL_PEND;
        if (rsp_ok)   st[rsp_idx] <= SL_READY;
        if (go_wait)  wait_q <= 1'b1;
        if (deliver) begin
          // the head slot becomes the new tail
          st[hp]    <= SL_NEED;
          sa[hp]    <= tail_addr;
          tail_addr <= tail_addr + 1'b1;
          hp        <= (hp == IDX_W'(DEPTH - 1)) ? '0 : hp + 1'b1;
          wait_q    <= 1'b0;
        end
      end
    end
  end

  // Checks
  logic [ADDR_W-1:0] req_dist;
  assign req_dist = mreq_addr - sa[hp];

  assert_ignore_cache_hit_R2: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && !lk_miss && !wait_q) |=> !lk_hit);

  assert_req_in_window_R3: assert property (@(posedge clk) disable iff (rst)
    mreq_valid |-> (req_dist < ADDR_W'(DEPTH)));

  assert_refill_advances_R4: assert property (@(posedge clk) disable iff (rst)
    refill_valid |-> (sa[hp] == refill_addr + 1'b1));

  assert_wait_holds_R5: assert property (@(posedge clk) disable iff (rst)
    (wait_q && st[hp] != SL_READY) |=> !refill_valid);
endmodule

// File: tb/stream_prefetch_buf_tb_top.sv
`timescale 1ns/1ps
module stream_prefetch_buf_tb_top;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam int DEPTH  = 4;
  localparam int SID_W  = 2;
  localparam int IDX_W  = 2;
  localparam int TAG_W  = SID_W + IDX_W;
  localparam int LAT    = 3;
  localparam int QMAX   = 512;
  localparam int WD_LIM = 100000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lk_valid = 1'b0, lk_miss = 1'b0;
  logic [ADDR_W-1:0] lk_addr = '0;
  logic lk_hit, refill_valid, mreq_valid;
  logic mreq_ready = 1'b1;
  logic [ADDR_W-1:0] refill_addr, mreq_addr;
  logic [DATA_W-1:0] refill_data;
  logic [TAG_W-1:0]  mreq_tag;
  logic              mrsp_valid = 1'b0;
  logic [TAG_W-1:0]  mrsp_tag = '0;
  logic [DATA_W-1:0] mrsp_data = '0;

  always #2 clk = ~clk;  // 250 MHz

  stream_prefetch_buf #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH), .SID_W(SID_W)) dut_i (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_miss(lk_miss), .lk_addr(lk_addr),
    .lk_hit(lk_hit), .refill_valid(refill_valid), .refill_addr(refill_addr),
    .refill_data(refill_data), .mreq_valid(mreq_valid), .mreq_ready(mreq_ready),
    .mreq_addr(mreq_addr), .mreq_tag(mreq_tag), .mrsp_valid(mrsp_valid),
    .mrsp_tag(mrsp_tag), .mrsp_data(mrsp_data)
  );

  function automatic logic [DATA_W-1:0] fdat(input logic [ADDR_W-1:0] a);
    return {a ^ 16'h5A5A, a};
  endfunction

  // Memory model: logs reads, answers in order after LAT cycles
  logic [ADDR_W-1:0] q_addr [QMAX];
  logic [TAG_W-1:0]  q_tag  [QMAX];
  int                q_cyc  [QMAX];
  int  q_rd = 0, q_wr = 0, cyc = 0;
  bit  mem_hold = 1'b0;

  always @(negedge clk) begin
    mrsp_valid = 1'b0;
    if (!mem_hold && q_rd < q_wr && (cyc - q_cyc[q_rd]) >= LAT) begin
      mrsp_valid = 1'b1;
      mrsp_tag   = q_tag[q_rd];
      mrsp_data  = fdat(q_addr[q_rd]);
      q_rd++;
    end
    if (!rst && mreq_valid && mreq_ready && q_wr < QMAX) begin
      q_addr[q_wr] = mreq_addr;
      q_tag[q_wr]  = mreq_tag;
      q_cyc[q_wr]  = cyc;
      q_wr++;
    end
    cyc++;
  end

  int n_chk = 0, n_fail = 0;

  always @(negedge clk) begin
    if (cyc == WD_LIM) begin
      $display("FAIL watchdog: actual %0d cycles expected < %0d", cyc, WD_LIM);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk + 1, n_fail + 1);
      $finish;
    end
  end

  task automatic check(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Present one lookup; returns at the negedge after the capturing edge
  task automatic lookup(input logic [ADDR_W-1:0] a, input logic miss);
    lk_valid = 1'b1; lk_addr = a; lk_miss = miss;
    @(negedge clk);
    lk_valid = 1'b0; lk_miss = 1'b0;
  endtask

  task automatic wait_refill();
    for (int i = 0; i < 40; i++) begin
      if (refill_valid) break;
      @(negedge clk);
    end
  endtask

  task automatic expect_refill(input string rq, input logic [ADDR_W-1:0] a);
    wait_refill();
    check(refill_valid, rq, "refill_valid", refill_valid, 1);
    check(refill_addr == a, rq, "refill_addr", refill_addr, a);
    check(refill_data == fdat(a), rq, "refill_data", refill_data, fdat(a));
  endtask

  // Vector: [31:16] address, [12] cache miss, [8] expected buffer hit, [7:0] idle after
  localparam logic [31:0] VEC [15] = '{
    32'h0100100C, 32'h01011100, 32'h01021100, 32'h02000002, 32'h01031100,
    32'h01051000, 32'h01061100, 32'h0107110C, 32'h01081100, 32'h01091100,
    32'h010A1100, 32'h03001008, 32'h03011100, 32'h03011000, 32'h03021100
  };

  initial begin
    int base;
    // R1: reset state
    idle(5);
    check(!lk_hit && !refill_valid && !mreq_valid, "R1", "outputs in reset",
          {lk_hit, refill_valid, mreq_valid}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(!lk_hit && !refill_valid && !mreq_valid, "R1", "outputs after reset",
          {lk_hit, refill_valid, mreq_valid}, 0);

    // R3 / R9: allocation issues DEPTH ascending reads with tag {1, k}
    base = q_wr;
    lookup(16'h0800, 1'b1);
    check(!lk_hit, "R3", "lk_hit on empty buffer", lk_hit, 0);
    idle(15);
    check(q_wr - base == DEPTH, "R3", "reads after allocation", q_wr - base, DEPTH);
    for (int k = 0; k < DEPTH; k++) begin
      check(q_addr[base+k] == 16'h0801 + k, "R3", "read address", q_addr[base+k], 16'h0801 + k);
      check(q_tag[base+k] == {2'd1, 2'(k)}, "R9", "read tag", q_tag[base+k], {2'd1, 2'(k)});
    end

    // R4: ready head refills on the next cycle; R6: one top-up read
    base = q_wr;
    lookup(16'h0801, 1'b1);
    check(lk_hit, "R4", "lk_hit", lk_hit, 1);
    check(refill_valid, "R4", "refill timing", refill_valid, 1);
    check(refill_addr == 16'h0801, "R4", "refill_addr", refill_addr, 16'h0801);
    check(refill_data == fdat(16'h0801), "R4", "refill_data", refill_data, fdat(16'h0801));
    idle(10);
    check(q_wr - base == 1, "R6", "top-up read count", q_wr - base, 1);
    check(q_addr[base] == 16'h0805, "R6", "top-up address", q_addr[base], 16'h0805);

    // R9: read held while memory is not ready
    mreq_ready = 1'b0;
    base = q_wr;
    lookup(16'h0900, 1'b1);
    idle(8);
    check(q_wr == base, "R9", "reads accepted while not ready", q_wr - base, 0);
    check(mreq_valid && mreq_addr == 16'h0901, "R9", "held read address", mreq_addr, 16'h0901);
    mreq_ready = 1'b1;
    idle(15);
    check(q_wr - base == DEPTH, "R9", "reads after ready", q_wr - base, DEPTH);

    // R7: a non-head entry does not hit
    lookup(16'h0902, 1'b1);
    check(!lk_hit, "R7", "lk_hit on second entry", lk_hit, 0);
    idle(1);
    check(!refill_valid, "R7", "no refill on second entry", refill_valid, 0);
    lookup(16'h0903, 1'b1);
    check(lk_hit, "R7", "lk_hit after restart", lk_hit, 1);
    expect_refill("R7", 16'h0903);
    idle(12);

    // Table walk
    foreach (VEC[v]) begin
      logic [ADDR_W-1:0] a;
      logic m, h;
      string rq;
      a = VEC[v][31:16];
      m = VEC[v][12];
      h = VEC[v][8];
      rq = !m ? "R2" : (h ? "R4" : "R3");
      lookup(a, m);
      check(lk_hit == h, rq, $sformatf("vector %0d lk_hit", v), lk_hit, h);
      if (h) expect_refill(rq, a);
      else check(!refill_valid, rq, $sformatf("vector %0d refill", v), refill_valid, 0);
      idle(VEC[v][7:0]);
    end
    idle(12);

    // R5: pending head, lookup during wait ignored
    mem_hold = 1'b1;
    lookup(16'h0C00, 1'b1);
    idle(6);
    lookup(16'h0C01, 1'b1);
    check(lk_hit, "R5", "lk_hit on pending head", lk_hit, 1);
    check(!refill_valid, "R5", "refill before data", refill_valid, 0);
    lookup(16'h5555, 1'b1);
    check(!lk_hit, "R5", "lookup during wait", lk_hit, 0);
    check(!refill_valid, "R5", "refill still waiting", refill_valid, 0);
    mem_hold = 1'b0;
    expect_refill("R5", 16'h0C01);
    idle(10);
    lookup(16'h0C02, 1'b1);
    check(lk_hit, "R5", "head kept after ignored lookup", lk_hit, 1);
    expect_refill("R5", 16'h0C02);
    idle(12);

    // R8: stale data from an abandoned stream is dropped
    mem_hold = 1'b1;
    lookup(16'h0A00, 1'b1);
    idle(6);
    lookup(16'h0B00, 1'b1);
    idle(6);
    mem_hold = 1'b0;
    idle(20);
    lookup(16'h0B01, 1'b1);
    check(lk_hit, "R8", "lk_hit on new stream", lk_hit, 1);
    expect_refill("R8", 16'h0B01);
    idle(3);
    lookup(16'h0B02, 1'b1);
    expect_refill("R8", 16'h0B02);

    idle(4);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule